// File: doc/BRIEF.md
# Partitioned Signature Compactor with Parity Reduction

This block watches a wide vector of captured system flip-flop values while the system runs. It folds those values, every enabled clock, into several independent multiple-input signature registers (MISRs). Each MISR receives its own fixed group of state bits. The grouping is a compile-time table, so structurally related bits can share one register. Because every MISR is linear and keeps absorbing new data, an error that reaches a signature stays in it for good. An error in one group leaves the other signatures untouched, which narrows where the fault came from.

Each signature is reduced to one parity bit by XORing a chosen subset of its bits. The per-group parities are then XORed into one composite bit that stands for the whole observed state. An off-chip tester can compare that single bit against a golden stream at its own slower rate.

When a finer look is needed, a serial scan-out shifts out only the signatures picked by a mask and skips the groups already known to be clean. Compaction pauses while the scan-out runs.

Top module: `sig_compactor`

## Requirements
- R1: After the asynchronous active-low reset, every signature is zero, `grp_par` and `all_par` are 0, and `so_valid` is 0.
- R2: When `en` is high, `clr` is low and no scan-out is running, each MISR g updates on the clock edge to `{s[W-2:0],0} ^ (s[W-1] ? POLY_g : 0) ^ in_g`. Here bit j of `in_g` is state bit `j*NUM_GRP+g` under the default table, and the default polynomials are 0x1D, 0x2B and 0x4D for groups 0, 1 and 2.
- R3: When `en` is low and no clear is applied, no signature changes.
- R4: A high `clr` zeroes every signature on the next edge and aborts any running scan-out. It takes priority over compaction.
- R5: `grp_par[g]` is the XOR of the signature bits of group g that are selected by its parity mask. The default masks are 0xFF for group 0, 0x0F for group 1 and 0xAA for group 2.
- R6: `all_par` is the XOR of all bits of `grp_par`.
- R7: A `scan_req` seen while idle with a nonzero `scan_sel` starts a scan-out. From the next cycle on, the selected signatures appear on `so_data`, MSB first, in ascending group index, one bit per cycle with `so_valid` high. That makes exactly MISR_W times popcount(`scan_sel`) cycles, after which `so_valid` falls.
- R8: While a scan-out runs, compaction is held even when `en` is high, so the parities stay constant.
- R9: A `scan_req` with an all-zero `scan_sel` starts nothing. A `scan_req` arriving during a running scan-out is ignored and does not change its order or length.
- R10: An error in a single state bit at one cycle leaves the signature of the group that owns the bit permanently different from the error-free run under identical later inputs. All other signatures stay equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Compaction enable |
| clr | input | 1 | Synchronous clear of all signatures |
| state_i | input | STATE_W | Captured system state bits |
| scan_req | input | 1 | Start a signature scan-out |
| scan_sel | input | NUM_GRP | Mask of groups to shift out |
| grp_par | output | NUM_GRP | Per-group parity bits |
| all_par | output | 1 | Composite parity |
| so_data | output | 1 | Serial signature data |
| so_valid | output | 1 | Strobe for each serial bit |

## Verification
On every cycle, the assertions check that signatures freeze with the enable low and hold during a scan-out. They also check that a clear zeroes them and ends a scan, that an empty selection starts nothing, and that zero signatures give zero parities. The feedback arithmetic, the bit-to-group mapping, the parity subsets, the exact serial order, and the confinement of a single injected error to its own group can only be shown by the bench. It compares long compaction runs against an independent model and sweeps every scan mask.

// File: rtl/sig_compactor.sv
module sig_compactor #(
  parameter int unsigned NUM_GRP = 3,
  parameter int unsigned MISR_W  = 8,
  parameter int unsigned STATE_W = NUM_GRP * MISR_W,
  parameter logic [NUM_GRP*MISR_W-1:0] POLY    = {8'h4D, 8'h2B, 8'h1D},
  parameter logic [NUM_GRP*MISR_W-1:0] PAR_SEL = {8'hAA, 8'h0F, 8'hFF},
  parameter int unsigned BIT_MAP [NUM_GRP*MISR_W] = '{
    0, 3, 6, 9, 12, 15, 18, 21,
    1, 4, 7, 10, 13, 16, 19, 22,
    2, 5, 8, 11, 14, 17, 20, 23}
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               clr,
  input  logic [STATE_W-1:0] state_i,
  input  logic               scan_req,
  input  logic [NUM_GRP-1:0] scan_sel,
  output logic [NUM_GRP-1:0] grp_par,
  output logic               all_par,
  output logic               so_data,
  output logic               so_valid
);
  localparam int unsigned IW = NUM_GRP > 1 ? $clog2(NUM_GRP) : 1;
  localparam int unsigned BW = MISR_W > 1 ? $clog2(MISR_W) : 1;

  logic [NUM_GRP-1:0][MISR_W-1:0] sig, sig_nxt;
  logic               busy;
  logic [NUM_GRP-1:0] sel_q;
  logic [IW-1:0]      cur_g, first_g, next_g;
  logic [BW-1:0]      cur_b;
  logic               first_ok, next_ok;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_misr
    logic [MISR_W-1:0] in_v;
    for (genvar j = 0; j < MISR_W; j++) begin : g_tap
      assign in_v[j] = state_i[BIT_MAP[g*MISR_W+j]];
    end
    assign sig_nxt[g] = {sig[g][MISR_W-2:0], 1'b0}
                      ^ (sig[g][MISR_W-1] ? POLY[g*MISR_W +: MISR_W] : '0)
                      ^ in_v;
    assign grp_par[g] = ^(sig[g] & PAR_SEL[g*MISR_W +: MISR_W]);
  end

  assign all_par = ^grp_par;

  always_comb begin
    first_ok = 1'b0;
    first_g  = '0;
    next_ok  = 1'b0;
    next_g   = '0;
    for (int i = NUM_GRP - 1; i >= 0; i--) begin
      if (scan_sel[i]) begin
        first_ok = 1'b1;
        first_g  = IW'(i);
      end
      if (sel_q[i] && i > int'(cur_g)) begin
        next_ok = 1'b1;
        next_g  = IW'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig   <= '0;
      busy  <= 1'b0;
      sel_q <= '0;
      cur_g <= '0;
      cur_b <= '0;
    end else if (clr) begin
      sig  <= '0;
      busy <= 1'b0;
    end else begin
      if (en && !busy) sig <= sig_nxt;
      if (!busy) begin
        if (scan_req && first_ok) begin
          busy  <= 1'b1;
          sel_q <= scan_sel;
          cur_g <= first_g;
          cur_b <= '0;
        end
      end else if (cur_b == BW'(MISR_W - 1)) begin
        if (next_ok) begin
          cur_g <= next_g;
          cur_b <= '0;
        end else begin
          busy <= 1'b0;
        end
      end else begin
        cur_b <= cur_b + 1'b1;
      end
    end
  end

  assign so_valid = busy;
  assign so_data  = busy & sig[cur_g][BW'(MISR_W - 1) - cur_b];

endmodule

// File: rtl/sig_compactor_chk.sv
module sig_compactor_chk #(
  parameter int unsigned NG = 3,
  parameter int unsigned W  = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   en,
  input logic                   clr,
  input logic                   scan_req,
  input logic [NG-1:0]          scan_sel,
  input logic                   so_valid,
  input logic [NG-1:0]          grp_par,
  input logic [NG-1:0][W-1:0]   sig
);
  AST_FREEZE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(sig)); // R3
  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (sig == '0 && !so_valid)); // R4
  AST_HOLD_IN_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    (so_valid && !clr) |=> $stable(sig)); // R8
  AST_EMPTY_MASK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!so_valid && scan_req && scan_sel == '0 && !clr) |=> !so_valid); // R9
  AST_ZERO_SIG_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (sig == '0) |-> (grp_par == '0)); // R5
endmodule

bind sig_compactor sig_compactor_chk #(.NG(NUM_GRP), .W(MISR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .clr(clr), .scan_req(scan_req),
  .scan_sel(scan_sel), .so_valid(so_valid), .grp_par(grp_par), .sig(sig));

// File: tb/test_sig_compactor.sv
module test_sig_compactor;
  localparam int NG = 3;
  localparam int W  = 8;
  localparam int SW = NG * W;

  logic clk = 0, rst_n = 0, en = 0, clr = 0, scan_req = 0;
  logic [SW-1:0] state_i = '0;
  logic [NG-1:0] scan_sel = '0;
  logic [NG-1:0] grp_par;
  logic all_par, so_data, so_valid;

  int checks = 0, fails = 0;
  logic [W-1:0] m [NG];
  logic [W-1:0] cap [NG];
  logic [W-1:0] base [NG];
  logic [SW-1:0] seq [20];

  always #5 clk = ~clk;

  sig_compactor i_sig_compactor (
    .clk(clk), .rst_n(rst_n), .en(en), .clr(clr), .state_i(state_i),
    .scan_req(scan_req), .scan_sel(scan_sel), .grp_par(grp_par),
    .all_par(all_par), .so_data(so_data), .so_valid(so_valid));

  function automatic logic [W-1:0] poly(int g);
    return g == 0 ? 8'h1D : (g == 1 ? 8'h2B : 8'h4D);
  endfunction
  function automatic logic [W-1:0] psel(int g);
    return g == 0 ? 8'hFF : (g == 1 ? 8'h0F : 8'hAA);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_par(string req);
    logic [NG-1:0] gp;
    for (int g = 0; g < NG; g++) gp[g] = ^(m[g] & psel(g));
    chk({req, " grp_par"}, 32'(grp_par), 32'(gp));
    chk({req, " all_par"}, 32'(all_par), 32'(^gp));
  endtask

  task automatic model_step(logic [SW-1:0] st);
    for (int g = 0; g < NG; g++) begin
      logic [W-1:0] inv, nx;
      for (int j = 0; j < W; j++) inv[j] = st[j*NG+g];
      nx = {m[g][W-2:0], 1'b0} ^ (m[g][W-1] ? poly(g) : '0) ^ inv;
      m[g] = nx;
    end
  endtask

  task automatic step(logic e, logic c, logic [SW-1:0] st, string req);
    @(negedge clk);
    en = e; clr = c; state_i = st;
    @(posedge clk);
    if (c) for (int g = 0; g < NG; g++) m[g] = '0;
    else if (e) model_step(st);
    #2;
    chk_par(req);
  endtask

  task automatic scan(logic [NG-1:0] mask, logic noise);
    int total, n;
    total = W * $countones(mask);
    n = 0;
    @(negedge clk);
    en = 0; clr = 0; scan_req = 1; scan_sel = mask;
    @(posedge clk); #2;
    for (int g = 0; g < NG; g++) begin
      if (mask[g]) begin
        for (int b = W - 1; b >= 0; b--) begin
          chk("R7 so_valid", 32'(so_valid), 32'd1);
          chk("R7 so_data", 32'(so_data), 32'(m[g][b]));
          cap[g][b] = so_data;
          chk_par("R8");
          n++;
          @(negedge clk);
          scan_req = noise && (n < total);
          scan_sel = ~mask;
          en = 1; state_i = SW'($urandom);
          @(posedge clk); #2;
        end
      end
    end
    @(negedge clk);
    scan_req = 0; en = 0;
    chk(mask == 0 ? "R9 empty mask" : "R7 end strobe", 32'(so_valid), 32'd0);
    chk_par("R8 after scan");
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int g = 0; g < NG; g++) m[g] = '0;
    repeat (3) @(posedge clk);
    #2;
    chk_par("R1");
    chk("R1 so_valid", 32'(so_valid), 32'd0);
    @(negedge clk) rst_n = 1;

    for (int k = 0; k < 300; k++) step(1'b1, 1'b0, SW'($urandom), "R2");
    for (int k = 0; k < 20; k++) step(1'b0, 1'b0, SW'($urandom), "R3");
    for (int k = 0; k < 50; k++) step(1'b1, 1'b0, SW'(32'h1 << (k % SW)), "R2 walk");
    step(1'b1, 1'b1, SW'($urandom), "R4");
    chk("R4 zero parity", 32'({grp_par, all_par}), 32'd0);

    for (int mk = 0; mk < 8; mk++) begin
      for (int k = 0; k < 7; k++) step(1'b1, 1'b0, SW'($urandom), "R6");
      scan(NG'(mk), mk[0]);
    end

    step(1'b1, 1'b0, '1, "R2");
    @(negedge clk); en = 0; scan_req = 1; scan_sel = 3'b111;
    @(posedge clk); #2;
    @(negedge clk); scan_req = 0; clr = 1;
    @(posedge clk); #2;
    for (int g = 0; g < NG; g++) m[g] = '0;
    chk("R4 abort scan", 32'(so_valid), 32'd0);
    chk_par("R4");
    @(negedge clk); clr = 0;

    for (int k = 0; k < 20; k++) seq[k] = SW'($urandom);
    step(1'b0, 1'b1, '0, "R10");
    for (int k = 0; k < 20; k++) step(1'b1, 1'b0, seq[k], "R10");
    scan(3'b111, 1'b0);
    for (int g = 0; g < NG; g++) base[g] = cap[g];
    step(1'b0, 1'b1, '0, "R10");
    for (int k = 0; k < 20; k++)
      step(1'b1, 1'b0, (k == 5) ? (seq[k] ^ SW'(1 << 4)) : seq[k], "R10");
    scan(3'b111, 1'b0);
    checks++;
    if (cap[1] === base[1]) begin
      fails++;
      $display("FAIL R10 faulty group: actual %h expected != %h", cap[1], base[1]);
    end
    chk("R10 group0 clean", 32'(cap[0]), 32'(base[0]));
    chk("R10 group2 clean", 32'(cap[2]), 32'(base[2]));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule